// File: doc/BRIEF.md
# Frame-Synchronized Filter Coefficient Register Bank

This block holds the run-time settings of a two-dimensional FIR image filter whose kernel is `KW` columns by `KH` rows. A host writes and reads 32-bit words over a simple memory-mapped port. Word 0 is a control word whose only live bit is a run enable. Word 1 is a read-only status word whose only live bit shows that a frame is in progress. Words from 2 upward hold one kernel coefficient each, in row-major order. Each coefficient is a signed two's complement integer of `CW` bits. Fractional coefficients are stored pre-scaled by a power of two that the filter datapath agrees on.

Host writes only change a staging copy of the settings. When the datapath pulses `frame_start` while the bank is idle, the bank samples the run enable. If the enable is set, the bank copies every staged coefficient into a shadow set, raises `frame_go` for one cycle and goes busy until `frame_done`. If the enable is clear, the bank stays stopped and the shadow set keeps its old contents. The filter only ever sees the shadow set on `coef_flat`, so software may rewrite coefficients at any time during a frame.

Top module: `fcb_coef_bank`

## Requirements
- R1: After reset, the run enable, the busy flag, `frame_go`, `host_rdata` and every staged and shadow coefficient are zero.
- R2: Word 0 takes the run enable from `host_wdata` bit 0. A read of word 0 returns the enable in bit 0 and zeros in bits 31:1.
- R3: A read of word 1 returns the busy flag in bit 0 and zeros in bits 31:1. Writes to word 1 have no effect.
- R4: Word 2+i (i from 0 to KW*KH-1) stores `host_wdata[CW-1:0]`. A read returns it sign-extended to 32 bits. Read data appears on `host_rdata` on the cycle after the edge that samples `host_rd`, and it holds until the next read.
- R5: Writes to any word above 1+KW*KH change no register. Reads from such a word return zero.
- R6: A `frame_start` sampled while idle with the enable at 1 causes three things after that edge: `frame_go` is high for exactly one cycle, the busy flag is 1, and `coef_flat` equals the staged set.
- R7: A `frame_start` sampled while idle with the enable at 0 leaves `frame_go` low, the busy flag at 0 and `coef_flat` unchanged.
- R8: `coef_flat` changes only on a capture. Coefficient writes made while busy stay invisible until the next capture.
- R9: The coefficient at kernel row r and column c lives at word 2+r*KW+c. It drives `coef_flat[(r*KW+c)*CW +: CW]`, so row 0 column 0 is in the least significant slot.
- R10: A `frame_done` sampled while busy clears the busy flag after that edge. A `frame_start` sampled while busy is ignored: no `frame_go`, and no change to `coef_flat`.
- R11: If a coefficient write and a capture are sampled on the same edge, the capture takes the value staged before that edge. The new value appears in the shadow set only at the next capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | AW | Host word address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered host read data |
| frame_start | input | 1 | Frame-start pulse from the datapath |
| frame_done | input | 1 | Frame-end pulse from the datapath |
| frame_go | output | 1 | One-cycle pulse: the frame may run |
| frame_busy | output | 1 | A frame is in progress |
| coef_flat | output | KW*KH*CW | Shadow coefficients, row-major, slot 0 in the low bits |

## Verification
Every result in this block is one register stage from its cause. Read data, `frame_go`, the busy flag and the shadow bus all change on the clock edge that samples the strobe or pulse. The bench drives each stimulus on a falling edge and holds it across exactly one rising edge. It then checks the result on the next falling edge, which is the first moment the result is valid and before any later edge could change it. The pulse-width check for `frame_go` looks one more falling edge later. The same-edge write-and-capture case raises both inputs on one falling edge, so the bench can tell whether the capture took the old staged value or the new one.

// File: rtl/fcb_pkg.sv
package fcb_pkg;
  localparam int unsigned BUS_W     = 32;
  localparam int unsigned CTRL_ADDR = 0;
  localparam int unsigned STAT_ADDR = 1;
  localparam int unsigned COEF_BASE = 2;

  typedef enum logic [0:0] {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/fcb_host_regs.sv
module fcb_host_regs
  import fcb_pkg::*;
#(
  parameter int unsigned KW = 3,
  parameter int unsigned KH = 3,
  parameter int unsigned CW = 16,
  parameter int unsigned AW = 8,
  localparam int unsigned NCOEF = KW * KH
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [AW-1:0]         addr,
  input  logic [BUS_W-1:0]      wdata,
  input  logic                  busy,
  output logic [BUS_W-1:0]      rdata,
  output logic                  go,
  output logic [NCOEF*CW-1:0]   stage_flat
);
  logic              go_q, go_d;
  logic [CW-1:0]     stage_q [NCOEF];
  logic [BUS_W-1:0]  rdata_q, rdata_d;

  // control word: enable bit only
  always_comb begin
    go_d = go_q;
    if (wr_en && (addr == AW'(CTRL_ADDR))) go_d = wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) go_q <= 1'b0;
    else        go_q <= go_d;
  end

  // staging coefficients, one register per kernel slot
  for (genvar g = 0; g < NCOEF; g++) begin : g_stage
    localparam logic [AW-1:0] SLOT_ADDR = AW'(COEF_BASE + g);
    logic          hit;
    logic [CW-1:0] nxt;

    always_comb begin
      hit = wr_en && (addr == SLOT_ADDR);
      nxt = stage_q[g];
      if (hit) nxt = wdata[CW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= '0;
      else        stage_q[g] <= nxt;
    end

    assign stage_flat[g*CW +: CW] = stage_q[g];
  end

  // read mux, registered on the read strobe
  always_comb begin
    rdata_d = '0;
    if (addr == AW'(CTRL_ADDR)) begin
      rdata_d[0] = go_q;
    end else if (addr == AW'(STAT_ADDR)) begin
      rdata_d[0] = busy;
    end else begin
      for (int i = 0; i < int'(NCOEF); i++) begin
        if (addr == AW'(COEF_BASE + i)) rdata_d = BUS_W'($signed(stage_q[i]));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;
  assign go    = go_q;
endmodule

// File: rtl/fcb_shadow_bank.sv
module fcb_shadow_bank #(
  parameter int unsigned NCOEF = 9,
  parameter int unsigned CW    = 16,
  localparam int unsigned FW   = NCOEF * CW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  logic [FW-1:0] stage_flat,
  output logic [FW-1:0] shadow_flat
);
  for (genvar g = 0; g < NCOEF; g++) begin : g_slot
    logic [CW-1:0] sh_q, sh_d;

    always_comb begin
      sh_d = sh_q;
      if (cap_en) sh_d = stage_flat[g*CW +: CW];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= sh_d;
    end

    assign shadow_flat[g*CW +: CW] = sh_q;
  end
endmodule

// File: rtl/fcb_frame_seq.sv
module fcb_frame_seq
  import fcb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic frame_start,
  input  logic frame_done,
  input  logic go,
  output logic capture,
  output logic busy,
  output logic frame_go
);
  seq_state_e state_q, state_d;
  logic       go_pulse_q, go_pulse_d;

  always_comb begin
    state_d    = state_q;
    capture    = 1'b0;
    go_pulse_d = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (frame_start && go) begin
          capture    = 1'b1;
          go_pulse_d = 1'b1;
          state_d    = SEQ_RUN;
        end
      end
      SEQ_RUN: begin
        if (frame_done) state_d = SEQ_IDLE;
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= SEQ_IDLE;
      go_pulse_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      go_pulse_q <= go_pulse_d;
    end
  end

  assign busy     = (state_q == SEQ_RUN);
  assign frame_go = go_pulse_q;
endmodule

// File: rtl/fcb_coef_bank.sv
module fcb_coef_bank #(
  parameter int unsigned KW = 3,
  parameter int unsigned KH = 3,
  parameter int unsigned CW = 16,
  parameter int unsigned AW = 8,
  localparam int unsigned NCOEF = KW * KH
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 host_wr,
  input  logic                 host_rd,
  input  logic [AW-1:0]        host_addr,
  input  logic [31:0]          host_wdata,
  output logic [31:0]          host_rdata,
  input  logic                 frame_start,
  input  logic                 frame_done,
  output logic                 frame_go,
  output logic                 frame_busy,
  output logic [NCOEF*CW-1:0]  coef_flat
);
  logic                go;
  logic                capture;
  logic                busy;
  logic [NCOEF*CW-1:0] stage_flat;

  fcb_host_regs #(.KW(KW), .KH(KH), .CW(CW), .AW(AW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (host_wr),
    .rd_en      (host_rd),
    .addr       (host_addr),
    .wdata      (host_wdata),
    .busy       (busy),
    .rdata      (host_rdata),
    .go         (go),
    .stage_flat (stage_flat)
  );

  fcb_frame_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .frame_done  (frame_done),
    .go          (go),
    .capture     (capture),
    .busy        (busy),
    .frame_go    (frame_go)
  );

  fcb_shadow_bank #(.NCOEF(NCOEF), .CW(CW)) u_shadow (
    .clk         (clk),
    .rst_n       (rst_n),
    .cap_en      (capture),
    .stage_flat  (stage_flat),
    .shadow_flat (coef_flat)
  );

  assign frame_busy = busy;
endmodule

// File: rtl/fcb_coef_bank_chk.sv
module fcb_coef_bank_chk #(
  parameter int unsigned KW = 3,
  parameter int unsigned KH = 3,
  parameter int unsigned CW = 16,
  parameter int unsigned AW = 8,
  localparam int unsigned NCOEF = KW * KH,
  localparam int unsigned LAST  = 1 + NCOEF
) (
  input logic                clk,
  input logic                rst_n,
  input logic                host_rd,
  input logic [AW-1:0]       host_addr,
  input logic [31:0]         host_rdata,
  input logic                frame_start,
  input logic                frame_done,
  input logic                frame_go,
  input logic                frame_busy,
  input logic [NCOEF*CW-1:0] coef_flat
);
  p_go_after_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_go |-> $past(frame_start));
  p_go_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_go |=> !frame_go);
  p_go_with_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_go |-> frame_busy);
  p_shadow_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_go |-> $stable(coef_flat));
  p_start_when_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_busy && frame_start) |=> !frame_go);
  p_done_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_busy && frame_done) |=> !frame_busy);
  p_flag_words_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && (host_addr < AW'(2))) |=> (host_rdata[31:1] == '0));
  p_oob_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && (host_addr > AW'(LAST))) |=> (host_rdata == '0));
endmodule

bind fcb_coef_bank fcb_coef_bank_chk #(.KW(KW), .KH(KH), .CW(CW), .AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .host_rd     (host_rd),
  .host_addr   (host_addr),
  .host_rdata  (host_rdata),
  .frame_start (frame_start),
  .frame_done  (frame_done),
  .frame_go    (frame_go),
  .frame_busy  (frame_busy),
  .coef_flat   (coef_flat)
);

// File: tb/tb_fcb_coef_bank.sv
module tb_fcb_coef_bank;
  localparam int KW = 3;
  localparam int KH = 3;
  localparam int CW = 16;
  localparam int AW = 8;
  localparam int N  = KW * KH;
  localparam int FW = N * CW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          host_wr = 1'b0;
  logic          host_rd = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [31:0]   host_wdata = '0;
  logic [31:0]   host_rdata;
  logic          frame_start = 1'b0;
  logic          frame_done = 1'b0;
  logic          frame_go;
  logic          frame_busy;
  logic [FW-1:0] coef_flat;

  int checks = 0;
  int errors = 0;

  logic [CW-1:0] m_stage [N];
  logic [CW-1:0] m_shadow [N];
  logic          m_go = 1'b0;

  always #2 clk = ~clk;

  fcb_coef_bank #(.KW(KW), .KH(KH), .CW(CW), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .frame_start(frame_start), .frame_done(frame_done), .frame_go(frame_go),
    .frame_busy(frame_busy), .coef_flat(coef_flat)
  );

  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'd0,   32'h0,         32'h0,         8'd1},  // R1 control
    '{1'b0, 8'd1,   32'h0,         32'h0,         8'd1},  // R1 status
    '{1'b0, 8'd5,   32'h0,         32'h0,         8'd1},  // R1 coefficient
    '{1'b1, 8'd0,   32'hFFFF_FFFF, 32'h0,         8'd2},
    '{1'b0, 8'd0,   32'h0,         32'h1,         8'd2},  // R2 upper bits zero
    '{1'b1, 8'd0,   32'hFFFF_FFFE, 32'h0,         8'd2},
    '{1'b0, 8'd0,   32'h0,         32'h0,         8'd2},  // R2 enable cleared
    '{1'b1, 8'd1,   32'hFFFF_FFFF, 32'h0,         8'd3},
    '{1'b0, 8'd1,   32'h0,         32'h0,         8'd3},  // R3 write ignored
    '{1'b1, 8'd2,   32'h0000_1234, 32'h0,         8'd4},
    '{1'b0, 8'd2,   32'h0,         32'h0000_1234, 8'd4},  // R4 positive
    '{1'b1, 8'd10,  32'h0000_8001, 32'h0,         8'd4},
    '{1'b0, 8'd10,  32'h0,         32'hFFFF_8001, 8'd4},  // R4 sign extension
    '{1'b1, 8'd6,   32'h1234_7FFF, 32'h0,         8'd4},
    '{1'b0, 8'd6,   32'h0,         32'h0000_7FFF, 8'd4},  // R4 truncation
    '{1'b1, 8'd11,  32'hDEAD_BEEF, 32'h0,         8'd5},
    '{1'b0, 8'd11,  32'h0,         32'h0,         8'd5},  // R5 read zero
    '{1'b0, 8'd255, 32'h0,         32'h0,         8'd5},  // R5 top address
    '{1'b0, 8'd10,  32'h0,         32'hFFFF_8001, 8'd5}   // R5 neighbour intact
  };

  task automatic check(input bit ok, input string req, input logic [255:0] act,
                       input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [FW-1:0] pack_shadow();
    logic [FW-1:0] f;
    for (int i = 0; i < N; i++) f[i*CW +: CW] = m_shadow[i];
    return f;
  endfunction

  function automatic void model_wr(input logic [7:0] a, input logic [31:0] d);
    if (a == 8'd0) m_go = d[0];
    else if (a >= 8'd2 && a <= 8'(1 + N)) m_stage[a - 8'd2] = d[CW-1:0];
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
    model_wr(a, d);
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    host_rd = 1'b1; host_addr = a;
    @(negedge clk);
    host_rd = 1'b0;
    check(host_rdata == exp, req, 256'(host_rdata), 256'(exp));
  endtask

  task automatic pulse_start();
    @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk);
    frame_done = 1'b1;
    @(negedge clk);
    frame_done = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_stage[i] = '0;
      m_shadow[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state at the ports
    check(coef_flat == '0, "R1 coef_flat", 256'(coef_flat), 256'(0));
    check(frame_go == 1'b0, "R1 frame_go", 256'(frame_go), 256'(0));
    check(frame_busy == 1'b0, "R1 busy", 256'(frame_busy), 256'(0));
    check(host_rdata == '0, "R1 rdata", 256'(host_rdata), 256'(0));

    // vector table walk
    for (int v = 0; v < NV; v++) begin
      if (VECS[v].wr) wr(VECS[v].addr, VECS[v].data);
      else rd_chk(VECS[v].addr, VECS[v].exp, $sformatf("R%0d vec%0d", VECS[v].req, v));
    end

    // R7: enable is 0, a start must not launch a frame
    pulse_start();
    check(frame_go == 1'b0, "R7 no go", 256'(frame_go), 256'(0));
    check(frame_busy == 1'b0, "R7 idle", 256'(frame_busy), 256'(0));
    check(coef_flat == pack_shadow(), "R7 shadow kept", 256'(coef_flat), 256'(pack_shadow()));

    // fill kernel and launch a frame (R6, R9)
    for (int i = 0; i < N; i++)
      wr(8'(2 + i), (i % 2) ? 32'(16'hF000 + 16'(i)) : 32'(16'h0100 + 16'(i)));
    wr(8'd0, 32'h1);
    pulse_start();
    for (int i = 0; i < N; i++) m_shadow[i] = m_stage[i];
    check(frame_go == 1'b1, "R6 go pulse", 256'(frame_go), 256'(1));
    check(frame_busy == 1'b1, "R6 busy", 256'(frame_busy), 256'(1));
    check(coef_flat == pack_shadow(), "R6 capture", 256'(coef_flat), 256'(pack_shadow()));
    check(coef_flat[5*CW +: CW] == 16'hF005, "R9 row1 col2 slot",
          256'(coef_flat[5*CW +: CW]), 256'(16'hF005));
    check(coef_flat[0 +: CW] == 16'h0100, "R9 origin slot",
          256'(coef_flat[0 +: CW]), 256'(16'h0100));
    @(negedge clk);
    check(frame_go == 1'b0, "R6 go one cycle", 256'(frame_go), 256'(0));
    rd_chk(8'd1, 32'h1, "R3 status busy");

    // R8: write during frame is invisible
    wr(8'd2, 32'h0000_0AAA);
    check(coef_flat == pack_shadow(), "R8 mid-frame write", 256'(coef_flat), 256'(pack_shadow()));
    rd_chk(8'd2, 32'h0000_0AAA, "R8 staged readback");

    // R10: start while busy ignored, done clears busy
    pulse_start();
    check(frame_go == 1'b0, "R10 start ignored", 256'(frame_go), 256'(0));
    check(coef_flat == pack_shadow(), "R10 shadow kept", 256'(coef_flat), 256'(pack_shadow()));
    pulse_done();
    check(frame_busy == 1'b0, "R10 done clears", 256'(frame_busy), 256'(0));
    rd_chk(8'd1, 32'h0, "R10 status idle");

    // R8: next capture picks up the staged value
    pulse_start();
    for (int i = 0; i < N; i++) m_shadow[i] = m_stage[i];
    check(coef_flat[0 +: CW] == 16'h0AAA, "R8 next capture",
          256'(coef_flat[0 +: CW]), 256'(16'h0AAA));
    pulse_done();

    // R11: write and capture on the same edge
    @(negedge clk);
    host_wr = 1'b1; host_addr = 8'd3; host_wdata = 32'h0000_5555;
    frame_start = 1'b1;
    @(negedge clk);
    host_wr = 1'b0; frame_start = 1'b0;
    for (int i = 0; i < N; i++) m_shadow[i] = m_stage[i];
    model_wr(8'd3, 32'h0000_5555);
    check(frame_go == 1'b1, "R11 capture ran", 256'(frame_go), 256'(1));
    check(coef_flat == pack_shadow(), "R11 old value captured",
          256'(coef_flat), 256'(pack_shadow()));
    rd_chk(8'd3, 32'h0000_5555, "R11 new value staged");
    pulse_done();
    pulse_start();
    for (int i = 0; i < N; i++) m_shadow[i] = m_stage[i];
    check(coef_flat[1*CW +: CW] == 16'h5555, "R11 new value next frame",
          256'(coef_flat[1*CW +: CW]), 256'(16'h5555));
    pulse_done();

    // R7: stop after running, staged changes stay out of the shadow
    wr(8'd0, 32'h0);
    wr(8'd4, 32'h0000_7777);
    pulse_start();
    check(frame_go == 1'b0, "R7 stopped no go", 256'(frame_go), 256'(0));
    check(frame_busy == 1'b0, "R7 stopped idle", 256'(frame_busy), 256'(0));
    check(coef_flat == pack_shadow(), "R7 stopped shadow",
          256'(coef_flat), 256'(pack_shadow()));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule